// File: doc/BRIEF.md
# Privileged Control Register Write Filter

This block holds two privileged control registers: a 32-bit secure-state configuration register and a 64-bit hypervisor configuration register. Each has its own write strobe and data bus, and both stored values drive output ports that other logic reads. On a write, the block clears every bit that is reserved for the current feature set before it stores the value. The feature set comes from three static configuration inputs: hypervisor level present, secure level present, and legacy 32-bit architecture.

A hypervisor-register write that changes how address translation works raises a one-cycle flush pulse, which tells the translation cache to discard its entries. This happens when the write changes the stage-2 enable bit, the walk-protect bit or the default-cacheable bit. The comparison uses the filtered value, so writing a reserved bit never raises a flush. Each output port returns the stored, filtered value of its register.

Top module: `ctlreg_filter`

## Requirements
- R1: After synchronous reset both registers read zero and the flush output is low.
- R2: A secure-register write stores the data ANDed with the implemented mask (bits 13..0 by default). All bits outside that mask read as zero.
- R3: When the hypervisor level is absent, a secure-register write stores bit 8 (hypervisor-call enable) as zero.
- R4: When the hypervisor level is absent and the legacy 32-bit input is high, a secure-register write also stores bit 7 (secure-call disable) as zero. In every other configuration, bit 7 is written as given.
- R5: A hypervisor-register write stores the data ANDed with the implemented mask (bits 33..0 by default). When the secure level is present, bit 29 (hypervisor-call disable) is stored as zero.
- R6: When the secure level is absent, a hypervisor-register write stores bit 19 (trap secure call) as zero, and bit 29 is writable.
- R7: In the cycle after a hypervisor-register write, the flush output is high exactly when the filtered new value differs from the old stored value in bit 0, bit 2 or bit 12.
- R8: The flush output is low in any cycle that does not follow a hypervisor-register write. A pulse lasts one cycle unless the next write also toggles a watched bit.
- R9: Without a write strobe, a register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_hyp_present | input | 1 | Hypervisor level implemented (static) |
| cfg_sec_present | input | 1 | Secure level implemented (static) |
| cfg_legacy32 | input | 1 | Legacy 32-bit architecture (static) |
| sec_wr_en | input | 1 | Secure register write strobe |
| sec_wr_data | input | 32 | Secure register write data |
| hyp_wr_en | input | 1 | Hypervisor register write strobe |
| hyp_wr_data | input | 64 | Hypervisor register write data |
| sec_cfg_q | output | 32 | Stored secure register value |
| hyp_cfg_q | output | 64 | Stored hypervisor register value |
| xlat_flush | output | 1 | Translation flush pulse |

## Verification
Stored values and the flush pulse all appear after the clock edge that samples the write strobe, which is one cycle after the stimulus. No result takes longer than that. The bench drives inputs on the falling edge. A behavioural model updates on the rising edge, and the bench compares the outputs with the model on the next falling edge, so each compare falls inside the cycle in which the result is due. Directed checks sample right after that edge to catch each masking case and each toggle or no-toggle case of the flush pulse. They sample again one cycle later to confirm the pulse has ended.

// File: rtl/ctlreg_pkg.sv
// Shared bit positions for the two control registers.
package ctlreg_pkg;
    // Secure-state register bit positions
    localparam int SEC_SMD_B = 7;
    localparam int SEC_HCE_B = 8;
    // Hypervisor register bit positions
    localparam int HYP_VM_B  = 0;
    localparam int HYP_PTW_B = 2;
    localparam int HYP_DC_B  = 12;
    localparam int HYP_TSC_B = 19;
    localparam int HYP_HCD_B = 29;
endpackage

// File: rtl/ctlreg_mask_gen.sv
// Builds the writable-bit masks of both registers from the static feature inputs.
// Assumes the feature inputs change only while no write is in flight.
module ctlreg_mask_gen
    import ctlreg_pkg::*;
#(
    parameter int SEC_W = 32,
    parameter int HYP_W = 64,
    parameter logic [SEC_W-1:0] SEC_IMPL = '1,
    parameter logic [HYP_W-1:0] HYP_IMPL = '1
) (
    input  logic             hyp_present,
    input  logic             sec_present,
    input  logic             legacy32,
    output logic [SEC_W-1:0] sec_mask,
    output logic [HYP_W-1:0] hyp_mask
);
    // Secure mask: remove the call-enable bit, and on the legacy architecture also the call-disable bit
    always_comb begin
        sec_mask = SEC_IMPL;
        if (!hyp_present) begin
            sec_mask[SEC_HCE_B] = 1'b0;
            if (legacy32) sec_mask[SEC_SMD_B] = 1'b0;
        end
    end

    // Hypervisor mask: the secure level decides which of the two trap bits is writable
    always_comb begin
        hyp_mask = HYP_IMPL;
        if (sec_present) hyp_mask[HYP_HCD_B] = 1'b0;
        else             hyp_mask[HYP_TSC_B] = 1'b0;
    end
endmodule

// File: rtl/ctlreg_hold.sv
// One filtered control register: it stores write data ANDed with a mask.
// It also exports the filtered next value so that other logic can compare it.
module ctlreg_hold #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] mask,
    output logic [W-1:0] filt,
    output logic [W-1:0] q
);
    // Filter the incoming write
    always_comb filt = wr_data & mask;

    // Store on write, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (wr_en) q <= filt;
    end
endmodule

// File: rtl/ctlreg_flush.sv
// Registered change detector: it pulses for one cycle when a write toggles any watched bit.
// Assumes old_q is the value held before the write and new_v the filtered value being written.
module ctlreg_flush #(
    parameter int W = 64,
    parameter logic [W-1:0] WATCH = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] old_q,
    input  logic [W-1:0] new_v,
    output logic         pulse
);
    logic [W-1:0] diff;

    // Bits that the write would toggle, restricted to the watched set
    always_comb diff = (old_q ^ new_v) & WATCH;

    // Register the pulse so it appears together with the new stored value
    always_ff @(posedge clk) begin
        if (!rst_n) pulse <= 1'b0;
        else        pulse <= wr_en && (|diff);
    end
endmodule

// File: rtl/ctlreg_filter.sv
// Top: two privileged control registers with feature-dependent write masking
// and a translation-flush pulse on hypervisor writes that change a watched bit.
// Assumes the cfg_* inputs are static during operation.
module ctlreg_filter
    import ctlreg_pkg::*;
#(
    parameter int SEC_W = 32,
    parameter int HYP_W = 64,
    parameter logic [SEC_W-1:0] SEC_IMPL_MASK = SEC_W'(32'h0000_3FFF),
    parameter logic [HYP_W-1:0] HYP_IMPL_MASK = HYP_W'(64'h0000_0003_FFFF_FFFF)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_hyp_present,
    input  logic             cfg_sec_present,
    input  logic             cfg_legacy32,
    input  logic             sec_wr_en,
    input  logic [SEC_W-1:0] sec_wr_data,
    input  logic             hyp_wr_en,
    input  logic [HYP_W-1:0] hyp_wr_data,
    output logic [SEC_W-1:0] sec_cfg_q,
    output logic [HYP_W-1:0] hyp_cfg_q,
    output logic             xlat_flush
);
    localparam logic [HYP_W-1:0] HYP_WATCH =
        (HYP_W'(1) << HYP_VM_B) | (HYP_W'(1) << HYP_PTW_B) | (HYP_W'(1) << HYP_DC_B);

    logic [SEC_W-1:0] sec_mask, sec_filt;
    logic [HYP_W-1:0] hyp_mask, hyp_filt;

    ctlreg_mask_gen #(
        .SEC_W(SEC_W), .HYP_W(HYP_W),
        .SEC_IMPL(SEC_IMPL_MASK), .HYP_IMPL(HYP_IMPL_MASK)
    ) u_mask (
        .hyp_present(cfg_hyp_present),
        .sec_present(cfg_sec_present),
        .legacy32   (cfg_legacy32),
        .sec_mask   (sec_mask),
        .hyp_mask   (hyp_mask)
    );

    ctlreg_hold #(.W(SEC_W)) u_sec (
        .clk(clk), .rst_n(rst_n), .wr_en(sec_wr_en), .wr_data(sec_wr_data),
        .mask(sec_mask), .filt(sec_filt), .q(sec_cfg_q)
    );

    ctlreg_hold #(.W(HYP_W)) u_hyp (
        .clk(clk), .rst_n(rst_n), .wr_en(hyp_wr_en), .wr_data(hyp_wr_data),
        .mask(hyp_mask), .filt(hyp_filt), .q(hyp_cfg_q)
    );

    ctlreg_flush #(.W(HYP_W), .WATCH(HYP_WATCH)) u_flush (
        .clk(clk), .rst_n(rst_n), .wr_en(hyp_wr_en),
        .old_q(hyp_cfg_q), .new_v(hyp_filt), .pulse(xlat_flush)
    );

    // The secure register has no change detector, so its filtered value is not used
    logic unused_sec_filt;
    always_comb unused_sec_filt = ^sec_filt;
endmodule

// File: rtl/ctlreg_filter_chk.sv
// Property checker for ctlreg_filter. It is attached by bind below.
module ctlreg_filter_chk
    import ctlreg_pkg::*;
#(
    parameter int SEC_W = 32,
    parameter int HYP_W = 64,
    parameter logic [SEC_W-1:0] SEC_IMPL_MASK = '1,
    parameter logic [HYP_W-1:0] HYP_IMPL_MASK = '1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_hyp_present,
    input logic             cfg_sec_present,
    input logic             cfg_legacy32,
    input logic             sec_wr_en,
    input logic             hyp_wr_en,
    input logic [SEC_W-1:0] sec_cfg_q,
    input logic [HYP_W-1:0] hyp_cfg_q,
    input logic             xlat_flush
);
    localparam logic [HYP_W-1:0] WATCH =
        (HYP_W'(1) << HYP_VM_B) | (HYP_W'(1) << HYP_PTW_B) | (HYP_W'(1) << HYP_DC_B);

    // R2
    sec_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_cfg_q & ~SEC_IMPL_MASK) == '0);

    // R3
    hce_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sec_wr_en) && !$past(cfg_hyp_present)) |-> !sec_cfg_q[SEC_HCE_B]);

    // R4
    smd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sec_wr_en) && !$past(cfg_hyp_present) && $past(cfg_legacy32))
            |-> !sec_cfg_q[SEC_SMD_B]);

    // R5
    hyp_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hyp_cfg_q & ~HYP_IMPL_MASK) == '0);

    // R5
    hcd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hyp_wr_en) && $past(cfg_sec_present)) |-> !hyp_cfg_q[HYP_HCD_B]);

    // R6
    tsc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hyp_wr_en) && !$past(cfg_sec_present)) |-> !hyp_cfg_q[HYP_TSC_B]);

    // R7
    flush_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xlat_flush |-> (((hyp_cfg_q ^ $past(hyp_cfg_q)) & WATCH) != '0));

    // R8
    flush_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(hyp_wr_en) |-> !xlat_flush);

    // R9
    sec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_wr_en |=> $stable(sec_cfg_q));

    // R9
    hyp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hyp_wr_en |=> $stable(hyp_cfg_q));
endmodule

bind ctlreg_filter ctlreg_filter_chk #(
    .SEC_W(SEC_W), .HYP_W(HYP_W),
    .SEC_IMPL_MASK(SEC_IMPL_MASK), .HYP_IMPL_MASK(HYP_IMPL_MASK)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .cfg_hyp_present(cfg_hyp_present), .cfg_sec_present(cfg_sec_present),
    .cfg_legacy32(cfg_legacy32),
    .sec_wr_en(sec_wr_en), .hyp_wr_en(hyp_wr_en),
    .sec_cfg_q(sec_cfg_q), .hyp_cfg_q(hyp_cfg_q), .xlat_flush(xlat_flush)
);

// File: tb/ctlreg_filter_bench.sv
`timescale 1ns/1ps
module ctlreg_filter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_hyp_present = 1'b1;
    logic        cfg_sec_present = 1'b1;
    logic        cfg_legacy32 = 1'b0;
    logic        sec_wr_en = 1'b0;
    logic [31:0] sec_wr_data = '0;
    logic        hyp_wr_en = 1'b0;
    logic [63:0] hyp_wr_data = '0;
    logic [31:0] sec_cfg_q;
    logic [63:0] hyp_cfg_q;
    logic        xlat_flush;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ctlreg_filter u_ctlreg_filter (
        .clk(clk), .rst_n(rst_n),
        .cfg_hyp_present(cfg_hyp_present), .cfg_sec_present(cfg_sec_present),
        .cfg_legacy32(cfg_legacy32),
        .sec_wr_en(sec_wr_en), .sec_wr_data(sec_wr_data),
        .hyp_wr_en(hyp_wr_en), .hyp_wr_data(hyp_wr_data),
        .sec_cfg_q(sec_cfg_q), .hyp_cfg_q(hyp_cfg_q), .xlat_flush(xlat_flush)
    );

    // Reference model, written from the requirements
    logic [31:0] m_sec;
    logic [63:0] m_hyp;
    logic        m_flush;

    function automatic logic [31:0] sec_allowed(bit hyp, bit leg);
        logic [31:0] a = 32'h0000_3FFF;
        if (!hyp) begin
            a[8] = 1'b0;
            if (leg) a[7] = 1'b0;
        end
        return a;
    endfunction

    function automatic logic [63:0] hyp_allowed(bit sec);
        logic [63:0] a = 64'h0000_0003_FFFF_FFFF;
        if (sec) a[29] = 1'b0; else a[19] = 1'b0;
        return a;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sec <= '0; m_hyp <= '0; m_flush <= 1'b0;
        end else begin
            logic [63:0] nh;
            nh = hyp_wr_data & hyp_allowed(cfg_sec_present);
            if (sec_wr_en) m_sec <= sec_wr_data & sec_allowed(cfg_hyp_present, cfg_legacy32);
            if (hyp_wr_en) m_hyp <= nh;
            m_flush <= hyp_wr_en && (nh[0] != m_hyp[0] || nh[2] != m_hyp[2] || nh[12] != m_hyp[12]);
        end
    end

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compare with the model on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 secure register vs model", 64'(sec_cfg_q), 64'(m_sec));
            check("R5 hypervisor register vs model", hyp_cfg_q, m_hyp);
            check("R7 flush vs model", 64'(xlat_flush), 64'(m_flush));
        end
    end

    task automatic wr_sec(logic [31:0] d);
        @(negedge clk); sec_wr_en = 1'b1; sec_wr_data = d;
        @(negedge clk); sec_wr_en = 1'b0;
    endtask

    task automatic wr_hyp(logic [63:0] d);
        @(negedge clk); hyp_wr_en = 1'b1; hyp_wr_data = d;
        @(negedge clk); hyp_wr_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check("R1 secure reset", 64'(sec_cfg_q), 64'h0);
        check("R1 hypervisor reset", hyp_cfg_q, 64'h0);
        check("R1 flush reset", 64'(xlat_flush), 64'h0);

        // R2: only bits 13..0 are kept
        wr_sec(32'hFFFF_FFFF);
        check("R2 secure mask", 64'(sec_cfg_q), 64'h3FFF);

        // R5 and R7: secure level present clears bit 29; watched bits rise, so flush
        wr_hyp(64'hFFFF_FFFF_FFFF_FFFF);
        check("R5 hypervisor mask", hyp_cfg_q, 64'h3_DFFF_FFFF);
        check("R7 flush on change", 64'(xlat_flush), 64'h1);
        @(negedge clk);
        check("R8 pulse ends", 64'(xlat_flush), 64'h0);

        // R8: the same value again gives no flush
        wr_hyp(64'h3_DFFF_FFFF);
        check("R8 no flush same value", 64'(xlat_flush), 64'h0);
        // R8: toggling bit 4 only gives no flush
        wr_hyp(64'h3_DFFF_FFEF);
        check("R8 no flush unwatched bit", 64'(xlat_flush), 64'h0);
        // R7: toggling bit 12 flushes
        wr_hyp(64'h3_DFFF_EFEF);
        check("R7 flush on bit 12", 64'(xlat_flush), 64'h1);
        // R7: a reserved bit toggle is filtered out before the compare
        wr_hyp(64'h0000_0103_DFFF_EFEF);
        check("R7 reserved bit no flush", 64'(xlat_flush), 64'h0);
        check("R5 reserved bit dropped", hyp_cfg_q, 64'h3_DFFF_EFEF);

        // R9: idle cycles hold both registers
        repeat (4) @(negedge clk);
        check("R9 secure hold", 64'(sec_cfg_q), 64'h3FFF);
        check("R9 hypervisor hold", hyp_cfg_q, 64'h3_DFFF_EFEF);

        // R3/R4: no hypervisor level, not legacy
        cfg_hyp_present = 1'b0; cfg_legacy32 = 1'b0;
        wr_sec(32'h0000_0180);
        check("R3 call-enable cleared, R4 bit 7 kept", 64'(sec_cfg_q), 64'h080);
        // R4: no hypervisor level, legacy
        cfg_legacy32 = 1'b1;
        wr_sec(32'h0000_0180);
        check("R4 call-disable cleared on legacy", 64'(sec_cfg_q), 64'h000);
        // R4: hypervisor present and legacy keeps both
        cfg_hyp_present = 1'b1;
        wr_sec(32'h0000_0180);
        check("R4 both kept with hypervisor", 64'(sec_cfg_q), 64'h180);

        // R6: no secure level clears bit 19 and keeps bit 29
        cfg_sec_present = 1'b0;
        wr_hyp(64'h0000_0000_2008_0000);
        check("R6 trap secure call cleared", hyp_cfg_q, 64'h2000_0000);
        check("R7 flush when bits 0/2 fall", 64'(xlat_flush), 64'h1);

        // R8: back-to-back toggling writes give two pulses
        @(negedge clk); hyp_wr_en = 1'b1; hyp_wr_data = 64'h1;
        @(negedge clk); hyp_wr_data = 64'h0;
        check("R8 first back-to-back pulse", 64'(xlat_flush), 64'h1);
        @(negedge clk); hyp_wr_en = 1'b0;
        check("R8 second back-to-back pulse", 64'(xlat_flush), 64'h1);
        @(negedge clk);
        check("R8 low after writes", 64'(xlat_flush), 64'h0);

        // R1: reset in mid-run clears the registers
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 secure after reset", 64'(sec_cfg_q), 64'h0);
        check("R1 hypervisor after reset", hyp_cfg_q, 64'h0);
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule